// File: doc/BRIEF.md
# Auto-Reload Nibble-Access Timer/Counter

An 8-bit up counter with an automatic reload value, meant to sit beside a 4-bit processor core. Software reaches it over a 4-bit data bus with a 2-bit address and separate read and write strobes. The 8-bit quantities are moved as two nibbles in a fixed order. Writing the upper nibble of the reload value commits the whole byte to the counter. Reading the upper nibble of the counter freezes its lower nibble, so that the next lower-nibble read gives a coherent byte.

The count source is chosen by an input bit. It is either the system clock divided by four, or an external pin. The pin passes through a two-stage synchronizer, and an input bit selects which pin edge counts. The chosen source feeds a power-of-two prescaler with eight ratios, picked by a 3-bit mode input. When the counter passes from 0xFF it takes the reload value again and raises a sticky request flag. The interrupt output is that flag gated by an enable bit.

Top module: `nib_timer`

## Requirements
- R1: After synchronous reset the counter, the reload value, the staged low nibble, the read latch, the read data, the request flag and the enable bit are all 0, and `irq` is low.
- R2: A write to address 0 only stores the nibble in a staging register. The counter keeps its value, which reads back unchanged.
- R3: A write to address 1 places {written nibble, staged nibble} into both the counter and the reload value at that clock edge. It also restarts the divide-by-four phase and the prescaler.
- R4: A read of address 1 returns counter bits 7:4 on `rd_data` one cycle after the strobe, and captures bits 3:0 in the same edge. A later read of address 0 returns the captured nibble, even if the counter has moved since.
- R5: Each prescaler output adds one to the counter. An output that arrives while the counter holds 0xFF loads the reload value instead and sets the request flag.
- R6: With `src_sel`=0 a source tick occurs every fourth clock. The first tick after a commit lands on the fourth edge after the commit edge.
- R7: With `src_sel`=1 the pin, XORed with `edge_sel`, is synchronized through two flops. `edge_sel`=0 counts low-to-high and `edge_sel`=1 counts high-to-low; the opposite edge does not count. Each pin phase must last at least two clocks.
- R8: `mode_sel` codes 0 to 7 select prescaler ratios 2048, 512, 128, 32, 8, 4, 2 and 1. After a commit the counter advances on every N-th source tick, the first advance coming on the N-th tick.
- R9: Address 2 holds the flags: bit 0 is the request and bit 1 is the enable. A write loads the enable from bit 1 and clears the request when bit 0 is 0; a 1 in bit 0 leaves it unchanged. A read returns {2'b00, enable, request}.
- R10: `irq` is high exactly when both the request flag and the enable bit are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin | input | 1 | External count input |
| src_sel | input | 1 | 0: clock divided by four, 1: external pin |
| edge_sel | input | 1 | 0: count rising pin edges, 1: count falling pin edges |
| mode_sel | input | 3 | Prescaler ratio code |
| addr | input | 2 | 0 low nibble, 1 high nibble, 2 flags |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 4 | Write nibble |
| rd_data | output | 4 | Registered read nibble |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is due one cycle after its strobe, so each read task drives the strobe at a falling edge and samples at the next falling edge. A commit shows in the counter at its own edge. An external pin change is counted on the third rising edge after it, so the bench holds every pin phase for three cycles and waits two more before it reads. With the internal source the request must stay low at the falling edge after the 63rd clock past a 0xF0 commit at ratio 1, and be high one edge later. The counter is frozen by selecting a still pin whenever it is read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NIB_W  = 4;
    localparam int CNT_W  = 2 * NIB_W;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 3;
    localparam int PRE_W  = 11;
    localparam int SHF_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic req;
    } flag_t;

    // prescaler ratio is 2**shift
    function automatic logic [SHF_W-1:0] shift_of_mode(input logic [MODE_W-1:0] m);
        logic [SHF_W-1:0] s;
        case (m)
            3'd0:    s = 4'd11;
            3'd1:    s = 4'd9;
            3'd2:    s = 4'd7;
            3'd3:    s = 4'd5;
            3'd4:    s = 4'd3;
            3'd5:    s = 4'd2;
            3'd6:    s = 4'd1;
            default: s = 4'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_src.sv
module tmr_src
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2,
    parameter int DIV    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic src_sel,
    input  logic edge_sel,
    input  logic ext_pin,
    output logic src_tick
);
    localparam int DIV_W = $clog2(DIV);

    logic              xin;
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic [DIV_W-1:0]  div_q;
    logic              ext_edge;
    logic              int_tick;

    assign xin = ext_pin ^ edge_sel;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= xin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_N-2:0], xin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            div_q  <= '0;
        end else begin
            prev_q <= sync_q[SYNC_N-1];
            if (restart) div_q <= '0;
            else         div_q <= div_q + DIV_W'(1);
        end
    end

    assign ext_edge = sync_q[SYNC_N-1] & ~prev_q;
    assign int_tick = (div_q == DIV_W'(DIV - 1));
    assign src_tick = src_sel ? ext_edge : int_tick;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              src_tick,
    input  logic [MODE_W-1:0] mode,
    output logic              cnt_tick
);
    logic [W-1:0]     pre_q;
    logic [W-1:0]     mask;
    logic [SHF_W-1:0] shift;

    always_comb begin
        shift = shift_of_mode(mode);
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < int'(shift));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart)  pre_q <= '0;
        else if (src_tick)   pre_q <= pre_q + W'(1);
    end

    assign cnt_tick = src_tick && ((pre_q & mask) == mask);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [NW-1:0] wr_nib,
    input  logic          cnt_tick,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] load_q,
    output logic [NW-1:0] stage_q,
    output logic          ovf
);
    logic at_top;

    assign at_top = (cnt_q == {CW{1'b1}});
    assign ovf    = cnt_tick && !wr_hi && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            load_q  <= '0;
            stage_q <= '0;
        end else begin
            if (wr_lo) stage_q <= wr_nib;
            if (wr_hi) begin
                load_q <= {wr_nib, stage_q};
                cnt_q  <= {wr_nib, stage_q};
            end else if (cnt_tick) begin
                cnt_q <= at_top ? load_q : cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        flag_wdata,
    input  logic [CW-1:0]     cnt_q,
    input  logic              ovf,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [NW-1:0]     rd_data,
    output flag_t             flag_q
);
    logic [NW-1:0] latch_q;
    logic          wr_flag;

    assign wr_lo   = wr_en && (addr == REG_LO);
    assign wr_hi   = wr_en && (addr == REG_HI);
    assign wr_flag = wr_en && (addr == REG_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= '0;
            latch_q <= '0;
            rd_data <= '0;
        end else begin
            if (wr_flag) begin
                flag_q.en <= flag_wdata[1];
                if (!flag_wdata[0]) flag_q.req <= 1'b0;
            end
            if (ovf) flag_q.req <= 1'b1;
            if (rd_en) begin
                case (addr)
                    REG_LO:   rd_data <= latch_q;
                    REG_HI: begin
                        rd_data <= cnt_q[CW-1:NW];
                        latch_q <= cnt_q[NW-1:0];
                    end
                    REG_FLAG: rd_data <= {{(NW-2){1'b0}}, flag_q.en, flag_q.req};
                    default:  rd_data <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/nib_timer.sv
module nib_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic              src_sel,
    input  logic              edge_sel,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [NIB_W-1:0]  wr_data,
    output logic [NIB_W-1:0]  rd_data,
    output logic              irq
);
    logic             wr_lo, wr_hi;
    logic             src_tick, cnt_tick, ovf;
    logic [CNT_W-1:0] cnt_q, load_q;
    logic [NIB_W-1:0] stage_q;
    flag_t            flag_q;
    logic             req, en;

    tmr_src #(.SYNC_N(2), .DIV(4)) u_src (
        .clk(clk), .rst(rst), .restart(wr_hi), .src_sel(src_sel),
        .edge_sel(edge_sel), .ext_pin(ext_pin), .src_tick(src_tick)
    );

    tmr_prescale #(.W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .restart(wr_hi), .src_tick(src_tick),
        .mode(mode_sel), .cnt_tick(cnt_tick)
    );

    tmr_core #(.NW(NIB_W), .CW(CNT_W)) u_core (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_nib(wr_data),
        .cnt_tick(cnt_tick), .cnt_q(cnt_q), .load_q(load_q), .stage_q(stage_q),
        .ovf(ovf)
    );

    tmr_regif #(.NW(NIB_W), .CW(CNT_W)) u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .flag_wdata(wr_data[1:0]), .cnt_q(cnt_q), .ovf(ovf), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .rd_data(rd_data), .flag_q(flag_q)
    );

    assign req = flag_q.req;
    assign en  = flag_q.en;
    assign irq = req & en;

endmodule

// File: rtl/nib_timer_chk.sv
module nib_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NIB_W-1:0]  wr_data,
    input logic [NIB_W-1:0]  rd_data,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load,
    input logic [NIB_W-1:0]  stage,
    input logic              tick,
    input logic              req
);
    logic commit;
    assign commit = wr_en && (addr == REG_HI);

    // R3
    commit_load_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt == {$past(wr_data), $past(stage)}));

    // R2
    stage_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_LO && !tick) |=> $stable(cnt));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !commit && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !commit && cnt == {CNT_W{1'b1}}) |=> (cnt == $past(load) && req));

    // R4
    hi_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_HI) |=> (rd_data == $past(cnt[CNT_W-1:NIB_W])));

    // R9
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(tick && !commit && cnt == {CNT_W{1'b1}}));

endmodule

bind nib_timer nib_timer_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cnt(cnt_q), .load(load_q),
    .stage(stage_q), .tick(cnt_tick), .req(req)
);

// File: tb/nib_timer_test.sv
module nib_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic       src_sel = 1'b0;
    logic       edge_sel = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic [3:0] rd_data;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    nib_timer uut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .src_sel(src_sel),
        .edge_sel(edge_sel), .mode_sel(mode_sel), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_cnt(output logic [7:0] v);
        logic [3:0] h, l;
        rd(2'd1, h);
        rd(2'd0, l);
        v = {h, l};
    endtask

    task automatic commit(input logic [7:0] v);
        wr(2'd0, v[3:0]);
        wr(2'd1, v[7:4]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        ext_pin = ~ext_pin; idle(3);
        ext_pin = ~ext_pin; idle(3);
        idle(2);
    endtask

    task automatic t_reset();
        logic [7:0] c;
        logic [3:0] f;
        chk("R1", "irq after reset", {7'd0, irq}, 8'h00);
        chk("R1", "rd_data after reset", {4'd0, rd_data}, 8'h00);
        rd_cnt(c);
        chk("R1", "counter after reset", c, 8'h00);
        rd(2'd2, f);
        chk("R1", "flags after reset", {4'd0, f}, 8'h00);
    endtask

    task automatic t_stage_commit();
        logic [7:0] c;
        src_sel = 1'b1; mode_sel = 3'd7; idle(4);
        wr(2'd0, 4'h6);
        rd_cnt(c);
        chk("R2", "low write alone", c, 8'h00);
        wr(2'd1, 4'hA);
        rd_cnt(c);
        chk("R3", "high write commits", c, 8'hA6);
    endtask

    task automatic t_coherent();
        logic [3:0] h, l;
        logic [7:0] c;
        rd(2'd1, h);
        pulse();
        rd(2'd0, l);
        chk("R4", "latched low after count", {h, l}, 8'hA6);
        rd_cnt(c);
        chk("R4", "fresh read", c, 8'hA7);
    endtask

    task automatic t_edges();
        logic [7:0] c;
        ext_pin = 1'b1; idle(5);
        rd_cnt(c);
        chk("R7", "rising counted", c, 8'hA8);
        ext_pin = 1'b0; idle(5);
        rd_cnt(c);
        chk("R7", "falling ignored", c, 8'hA8);
        ext_pin = 1'b1; idle(5);
        edge_sel = 1'b1; idle(5);
        commit(8'h30);
        ext_pin = 1'b0; idle(5);
        rd_cnt(c);
        chk("R7", "falling counted", c, 8'h31);
        ext_pin = 1'b1; idle(5);
        rd_cnt(c);
        chk("R7", "rising ignored", c, 8'h31);
        ext_pin = 1'b0; idle(5);
        edge_sel = 1'b0; idle(5);
    endtask

    task automatic t_overflow();
        logic [7:0] c;
        logic [3:0] f;
        wr(2'd2, 4'b0010);
        commit(8'hFD);
        pulse(); pulse();
        rd_cnt(c);
        chk("R5", "at top", c, 8'hFF);
        rd(2'd2, f);
        chk("R9", "no request yet", {4'd0, f}, 8'h02);
        chk("R10", "irq low before wrap", {7'd0, irq}, 8'h00);
        pulse();
        rd_cnt(c);
        chk("R5", "reload on wrap", c, 8'hFD);
        rd(2'd2, f);
        chk("R9", "request set", {4'd0, f}, 8'h03);
        chk("R10", "irq high", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_flags();
        logic [3:0] f;
        wr(2'd2, 4'b0001);
        rd(2'd2, f);
        chk("R9", "one in bit0 keeps request", {4'd0, f}, 8'h01);
        chk("R10", "irq gated by enable", {7'd0, irq}, 8'h00);
        wr(2'd2, 4'b0011);
        chk("R10", "irq re-enabled", {7'd0, irq}, 8'h01);
        wr(2'd2, 4'b0010);
        rd(2'd2, f);
        chk("R9", "zero in bit0 clears", {4'd0, f}, 8'h02);
        chk("R10", "irq after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_prescale();
        logic [7:0] c;
        mode_sel = 3'd6;
        commit(8'h00);
        pulse();
        rd_cnt(c);
        chk("R8", "ratio 2 first tick", c, 8'h00);
        pulse();
        rd_cnt(c);
        chk("R8", "ratio 2 second tick", c, 8'h01);
        mode_sel = 3'd5;
        commit(8'h00);
        for (int i = 0; i < 3; i++) pulse();
        rd_cnt(c);
        chk("R8", "ratio 4 three ticks", c, 8'h00);
        pulse();
        rd_cnt(c);
        chk("R8", "ratio 4 fourth tick", c, 8'h01);
        mode_sel = 3'd0;
        commit(8'h00);
        for (int i = 0; i < 2047; i++) pulse();
        rd_cnt(c);
        chk("R8", "ratio 2048 before", c, 8'h00);
        pulse();
        rd_cnt(c);
        chk("R8", "ratio 2048 reached", c, 8'h01);
    endtask

    task automatic t_internal();
        logic [7:0] c;
        mode_sel = 3'd7;
        wr(2'd2, 4'b0010);
        wr(2'd0, 4'h0);
        @(negedge clk);
        src_sel = 1'b0;
        wr(2'd1, 4'hF);
        repeat (63) @(posedge clk);
        @(negedge clk);
        chk("R6", "no wrap after 63 clocks", {7'd0, irq}, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R6", "wrap on 64th clock", {7'd0, irq}, 8'h01);
        src_sel = 1'b1;
        rd_cnt(c);
        chk("R5", "internal reload", c, 8'hF0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_stage_commit();
        t_coherent();
        t_edges();
        t_overflow();
        t_flags();
        t_prescale();
        t_internal();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule